// File: doc/BRIEF.md
# Watchdog Timer with Wake-Up Alarm

This block counts system clocks toward a selectable timeout. Each timeout sets a watchdog flag and restarts the count, so the timer also works as a periodic alarm. When the watchdog interrupt enable is set, the flag raises an interrupt request, which can wake a core that is idling. When the reset function is enabled and software does not restart the timer in time, the block waits a short grace window after the timeout and then emits a one-cycle system reset pulse. A restart written during the grace window cancels that reset.

The block also holds the cause-of-reset flags: a power-on flag and a watchdog-reset flag. It also holds a power-fail flag. A supply-drop comparator sets the power-fail flag, and software can also set it to force an interrupt. When both interrupt sources are pending, power-fail wins, and a one-bit source select tells the interrupt controller which source is active. A stop input freezes all counting, because the clock is gated in that mode.

Software reaches two 8-bit registers through a single write/read port. Register 0 holds the control and flag bits. Register 1 holds the period select and the watchdog interrupt enable.

Top module: `wdt_wake`

## Requirements
- R1: While `por_n` is low at a clock edge, all state is cleared except the power-on flag, which is set. Afterwards register 0 reads 0x40, register 1 reads 0x00, and `irq_o` and `wdt_rst_o` are both 0.
- R2: Writing register 0 with bit 0 = 1 restarts the timeout count from zero. Bit 0 always reads 0.
- R3: A timeout occurs after P counting cycles following a restart. A timeout sets register 0 bit 3 (watchdog flag) whatever the enables are, and restarts the count, so the flag recurs periodically. Writing 0 to bit 3 clears it, and writing 1 leaves it unchanged. A timeout in the same cycle as the clearing write wins.
- R4: `irq_o` is raised for the watchdog only while bit 3 and register 1 bit 2 (watchdog interrupt enable) are both set.
- R5: With register 0 bit 1 (reset enable) set, a timeout that is not followed by a restart drives `wdt_rst_o` high for exactly one cycle. The pulse comes GRACE_CYCLES cycles after the timeout edge.
- R6: A restart written during the grace window cancels the pending reset.
- R7: With bit 1 clear, no reset pulse is produced, and the count keeps running and timing out.
- R8: On the clock edge that ends a reset pulse, bit 2 (watchdog-reset flag) is set, bit 3 is cleared and the count restarts. Bit 2 is cleared only by writing 0 to it or by `por_n`.
- R9: Bit 6 (power-on flag) stays set until software writes 0 to it.
- R10: Register 1 bits 1:0 (value s) select P = 2^(TO_BASE_LOG2 + s*TO_STEP_LOG2) clocks.
- R11: While `stop_i` is high, neither the timeout count nor the grace count advances.
- R12: Bit 4 (power-fail flag) is set on any cycle in which `pfail_i` is high. Otherwise a write to register 0 loads it from the written bit, so writing 1 forces it. The flag requests an interrupt when bit 5 (power-fail enable) is set.
- R13: When both requests are active, `irq_src_o` is 0 (power-fail). It is 1 only when the watchdog request alone is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| stop_i | input | 1 | Stop mode, freezes all counting |
| pfail_i | input | 1 | Supply-drop comparator output |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Interrupt request |
| irq_src_o | output | 1 | Interrupt source: 0 power-fail, 1 watchdog |
| wdt_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
All register flags change on the clock edge that samples their cause. Their readback, `irq_o` and `irq_src_o` follow combinationally and are due in the cycle after that edge. The watchdog flag appears P edges after the restart write. The reset pulse is visible for one cycle starting GRACE_CYCLES edges after the timeout edge. Its consequences (flag updates and count restart) land on the next edge. The bench steps a behavioural model on each rising edge with the inputs it applied, and drives inputs just after the falling edge. It compares every output at the falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/wdt_wake_pkg.sv
// Shared field positions and types for the watchdog block.
// Assumes two 8-bit registers selected by a one-bit address.
package wdt_wake_pkg;
    // register 0 fields
    localparam int unsigned F_KICK  = 0;
    localparam int unsigned F_RSTEN = 1;
    localparam int unsigned F_WDRST = 2;
    localparam int unsigned F_WDINT = 3;
    localparam int unsigned F_PF    = 4;
    localparam int unsigned F_PFEN  = 5;
    localparam int unsigned F_POR   = 6;
    // register 1 fields
    localparam int unsigned F_WDEN  = 2;

    typedef enum logic {
        SRC_PFAIL = 1'b0,
        SRC_WDOG  = 1'b1
    } irq_src_e;
endpackage

// File: rtl/wdt_wake_timebase.sv
// Timeout counter: counts enabled clocks and flags a timeout when the
// selected period has elapsed, then wraps. Assumes restart_i is a pulse.
module wdt_wake_timebase #(
    parameter int unsigned TO_BASE_LOG2 = 17,
    parameter int unsigned TO_STEP_LOG2 = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       stop_i,
    input  logic       restart_i,
    input  logic [1:0] sel_i,
    output logic       timeout_o
);
    localparam int unsigned CW = TO_BASE_LOG2 + 3 * TO_STEP_LOG2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_tab [4];

    // one terminal count per period select value
    for (genvar i = 0; i < 4; i++) begin : g_lim
        assign lim_tab[i] = CW'((64'd1 << (TO_BASE_LOG2 + i * TO_STEP_LOG2)) - 64'd1);
    end

    // timeout when the count reaches the selected terminal value
    assign timeout_o = !stop_i && !restart_i && (cnt_q >= lim_tab[sel_i]);

    // advance, wrap or restart the count
    always_ff @(posedge clk) begin
        if (!por_n || restart_i)  cnt_q <= '0;
        else if (timeout_o)       cnt_q <= '0;
        else if (!stop_i)         cnt_q <= cnt_q + 1'b1;
    end

    p_stop_freeze_r11: assert property (@(posedge clk) disable iff (!por_n)
        (stop_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_wake_grace.sv
// Grace window: armed by a timeout while reset is enabled, counts
// GRACE_CYCLES enabled clocks, then issues a one-cycle reset pulse.
// Assumes GRACE_CYCLES is shorter than the shortest timeout period.
module wdt_wake_grace #(
    parameter int unsigned GRACE_CYCLES = 512
) (
    input  logic clk,
    input  logic por_n,
    input  logic stop_i,
    input  logic enable_i,
    input  logic restart_i,
    input  logic timeout_i,
    output logic rst_pulse_o
);
    localparam int unsigned GW = $clog2(GRACE_CYCLES + 1);

    logic          armed_q;
    logic [GW-1:0] gcnt_q;

    // arm on timeout, count down the window, fire the pulse
    always_ff @(posedge clk) begin
        if (!por_n) begin
            armed_q     <= 1'b0;
            gcnt_q      <= '0;
            rst_pulse_o <= 1'b0;
        end else begin
            rst_pulse_o <= 1'b0;
            if (restart_i || !enable_i) begin
                armed_q <= 1'b0;
            end else if (timeout_i) begin
                armed_q <= 1'b1;
                gcnt_q  <= '0;
            end else if (armed_q && !stop_i) begin
                if (gcnt_q == GW'(GRACE_CYCLES - 1)) begin
                    armed_q     <= 1'b0;
                    rst_pulse_o <= 1'b1;
                end else begin
                    gcnt_q <= gcnt_q + 1'b1;
                end
            end
        end
    end

    p_grace_stop_r11: assert property (@(posedge clk) disable iff (!por_n)
        (armed_q && stop_i && !restart_i && enable_i) |=> (armed_q && $stable(gcnt_q)));
endmodule

// File: rtl/wdt_wake_regs.sv
// Control and flag registers with interrupt request and source select.
// Assumes rst_ev_i is the watchdog reset pulse and timeout_i a pulse.
module wdt_wake_regs
    import wdt_wake_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       pfail_i,
    input  logic       wr_en_i,
    input  logic       addr_i,
    input  logic [7:0] wdata_i,
    input  logic       timeout_i,
    input  logic       rst_ev_i,
    output logic [7:0] rdata_o,
    output logic       kick_o,
    output logic       rst_en_o,
    output logic [1:0] sel_o,
    output logic       irq_o,
    output logic       irq_src_o
);
    logic wr0, wr1;
    logic rsten_q, pfen_q, wden_q;
    logic wdint_q, wdrst_q, pf_q, por_q;
    logic pf_req, wd_req;

    assign wr0    = wr_en_i && !addr_i;
    assign wr1    = wr_en_i && addr_i;
    assign kick_o = wr0 && wdata_i[F_KICK];

    // plain control bits, loaded by writes
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rsten_q <= 1'b0;
            pfen_q  <= 1'b0;
            wden_q  <= 1'b0;
            sel_o   <= 2'd0;
        end else begin
            if (wr0) begin
                rsten_q <= wdata_i[F_RSTEN];
                pfen_q  <= wdata_i[F_PFEN];
            end
            if (wr1) begin
                wden_q <= wdata_i[F_WDEN];
                sel_o  <= wdata_i[1:0];
            end
        end
    end

    // flags with hardware set and software clear rules
    always_ff @(posedge clk) begin
        if (!por_n) begin
            wdint_q <= 1'b0;
            wdrst_q <= 1'b0;
            pf_q    <= 1'b0;
            por_q   <= 1'b1;
        end else begin
            if (rst_ev_i)                       wdint_q <= 1'b0;
            else if (timeout_i)                 wdint_q <= 1'b1;
            else if (wr0 && !wdata_i[F_WDINT])  wdint_q <= 1'b0;

            if (rst_ev_i)                       wdrst_q <= 1'b1;
            else if (wr0 && !wdata_i[F_WDRST])  wdrst_q <= 1'b0;

            if (pfail_i)                        pf_q <= 1'b1;
            else if (wr0)                       pf_q <= wdata_i[F_PF];

            if (wr0 && !wdata_i[F_POR])         por_q <= 1'b0;
        end
    end

    // request combining with power-fail priority
    assign pf_req    = pf_q && pfen_q;
    assign wd_req    = wdint_q && wden_q;
    assign irq_o     = pf_req || wd_req;
    assign irq_src_o = pf_req ? SRC_PFAIL : (wd_req ? SRC_WDOG : SRC_PFAIL);
    assign rst_en_o  = rsten_q;

    // read mux
    always_comb begin
        rdata_o = 8'h00;
        if (addr_i) begin
            rdata_o[1:0]    = sel_o;
            rdata_o[F_WDEN] = wden_q;
        end else begin
            rdata_o[F_RSTEN] = rsten_q;
            rdata_o[F_WDRST] = wdrst_q;
            rdata_o[F_WDINT] = wdint_q;
            rdata_o[F_PF]    = pf_q;
            rdata_o[F_PFEN]  = pfen_q;
            rdata_o[F_POR]   = por_q;
        end
    end

    p_wdint_set_r3: assert property (@(posedge clk) disable iff (!por_n)
        timeout_i |=> wdint_q);
    p_rstflag_cause_r8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wdrst_q) |-> $past(rst_ev_i));
    p_por_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
        (por_q && !(wr0 && !wdata_i[F_POR])) |=> por_q);
    p_pf_prio_r13: assert property (@(posedge clk) disable iff (!por_n)
        (pf_q && pfen_q) |-> (irq_o && irq_src_o == SRC_PFAIL));
endmodule

// File: rtl/wdt_wake.sv
// Watchdog timer top: timeout counter, grace window and register file.
// The reset pulse is fed back as a restart and a flag event; control
// bits survive it. Assumes GRACE_CYCLES < 2**TO_BASE_LOG2.
module wdt_wake #(
    parameter int unsigned TO_BASE_LOG2 = 17,
    parameter int unsigned TO_STEP_LOG2 = 3,
    parameter int unsigned GRACE_CYCLES = 512
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       stop_i,
    input  logic       pfail_i,
    input  logic       wr_en_i,
    input  logic       addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_o,
    output logic       irq_src_o,
    output logic       wdt_rst_o
);
    logic       kick, rst_en, timeout, restart;
    logic [1:0] sel;

    assign restart = kick || wdt_rst_o;

    wdt_wake_timebase #(
        .TO_BASE_LOG2(TO_BASE_LOG2),
        .TO_STEP_LOG2(TO_STEP_LOG2)
    ) u_tb (
        .clk(clk), .por_n(por_n), .stop_i(stop_i), .restart_i(restart),
        .sel_i(sel), .timeout_o(timeout)
    );

    wdt_wake_grace #(.GRACE_CYCLES(GRACE_CYCLES)) u_gr (
        .clk(clk), .por_n(por_n), .stop_i(stop_i), .enable_i(rst_en),
        .restart_i(restart), .timeout_i(timeout), .rst_pulse_o(wdt_rst_o)
    );

    wdt_wake_regs u_regs (
        .clk(clk), .por_n(por_n), .pfail_i(pfail_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .timeout_i(timeout),
        .rst_ev_i(wdt_rst_o), .rdata_o(rdata_o), .kick_o(kick),
        .rst_en_o(rst_en), .sel_o(sel), .irq_o(irq_o), .irq_src_o(irq_src_o)
    );

    p_rst_needs_en_r5: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_o |-> $past(rst_en));
    p_rst_single_r5: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_o |=> !wdt_rst_o);
endmodule

// File: tb/wdt_wake_test.sv
`timescale 1ns/1ps
module wdt_wake_test;
    localparam int BASE = 6, STEP = 1, GR = 16;

    logic clk = 1'b0, por_n = 1'b0, stop_i = 1'b0, pfail_i = 1'b0;
    logic wr_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    wire  [7:0] rdata;
    wire        irq, src, rst;

    always #2.5 clk = ~clk;

    wdt_wake #(.TO_BASE_LOG2(BASE), .TO_STEP_LOG2(STEP), .GRACE_CYCLES(GR)) uut (
        .clk(clk), .por_n(por_n), .stop_i(stop_i), .pfail_i(pfail_i),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .irq_src_o(src), .wdt_rst_o(rst)
    );

    int    checks = 0, errors = 0, rst_seen = 0;
    string tag = "R1";
    bit    started = 0, done = 0;

    // behavioural reference state
    int m_cnt = 0, m_g = 0, m_sel = 0;
    bit m_armed = 0, m_rst = 0, m_rsten = 0, m_wdrst = 0, m_wdint = 0;
    bit m_pf = 0, m_pfen = 0, m_por = 1, m_wden = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // model step on each rising edge, using the applied inputs
    always @(posedge clk) begin : model
        bit ev, kick, wr0, wr1, to, en_old;
        int lim;
        started = 1;
        if (!por_n) begin
            m_cnt = 0; m_g = 0; m_sel = 0; m_armed = 0; m_rst = 0; m_rsten = 0;
            m_wdrst = 0; m_wdint = 0; m_pf = 0; m_pfen = 0; m_por = 1; m_wden = 0;
        end else begin
            ev = m_rst; m_rst = 0;
            wr0 = wr_en && !addr; wr1 = wr_en && addr;
            kick = wr0 && wdata[0];
            en_old = m_rsten;
            lim = (1 << (BASE + m_sel * STEP)) - 1;
            to = 0;
            if (ev || kick) m_cnt = 0;
            else if (!stop_i) begin
                if (m_cnt >= lim) begin m_cnt = 0; to = 1; end
                else m_cnt++;
            end
            if (ev || kick || !en_old) m_armed = 0;
            else if (to) begin m_armed = 1; m_g = 0; end
            else if (m_armed && !stop_i) begin
                if (m_g == GR - 1) begin m_armed = 0; m_rst = 1; end
                else m_g++;
            end
            if (ev) m_wdint = 0; else if (to) m_wdint = 1; else if (wr0 && !wdata[3]) m_wdint = 0;
            if (ev) m_wdrst = 1; else if (wr0 && !wdata[2]) m_wdrst = 0;
            if (pfail_i) m_pf = 1; else if (wr0) m_pf = wdata[4];
            if (wr0 && !wdata[6]) m_por = 0;
            if (wr0) begin m_rsten = wdata[1]; m_pfen = wdata[5]; end
            if (wr1) begin m_wden = wdata[2]; m_sel = int'(wdata[1:0]); end
        end
    end

    // compare every output at the falling edge
    always @(negedge clk) begin : compare
        logic [7:0] exp_rd;
        bit pfr, wdr;
        if (started && !done) begin
            exp_rd = addr ? {5'b0, m_wden, 2'(m_sel)}
                          : {1'b0, m_por, m_pfen, m_pf, m_wdint, m_wdrst, m_rsten, 1'b0};
            pfr = m_pf && m_pfen;
            wdr = m_wdint && m_wden;
            chk(rdata === exp_rd, "rdata", int'(rdata), int'(exp_rd));
            chk(irq === (pfr || wdr), "irq", int'(irq), int'(pfr || wdr));
            chk(src === (!pfr && wdr), "irq_src", int'(src), int'(!pfr && wdr));
            chk(rst === m_rst, "wdt_rst", int'(rst), int'(m_rst));
            if (rst === 1'b1) rst_seen++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr_en = 1'b0; addr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int r;
        // R1: reset state
        idle(3); por_n = 1'b1;
        idle(2); chk(rdata === 8'h40, "R1 reg0 after por", int'(rdata), 'h40);
        addr = 1'b1; idle(2); addr = 1'b0;
        // R3, R10: periodic flag at the shortest period, then clear
        tag = "R3"; idle(70);
        chk(rdata[3] === 1'b1, "R3 flag after timeout", int'(rdata[3]), 1);
        wr(0, 8'h40);
        // R4: interrupt only with enable
        tag = "R4"; idle(70); wr(1, 8'h04); idle(5); wr(0, 8'h40); idle(70);
        // R10: longer periods
        tag = "R10"; wr(1, 8'h05); idle(140); wr(1, 8'h07); idle(530); wr(1, 8'h04);
        // R2: repeated restarts keep the flag clear
        tag = "R2"; wr(0, 8'h41);
        for (int i = 0; i < 5; i++) begin idle(40); wr(0, 8'h41); end
        chk(rdata[3] === 1'b0, "R2 no timeout while kicked", int'(rdata[3]), 0);
        // R5, R8: reset after grace window
        tag = "R5"; r = rst_seen; wr(0, 8'h43); idle(64 + GR + 6);
        chk(rst_seen == r + 1, "R5 one reset pulse", rst_seen - r, 1);
        tag = "R8"; chk(rdata[2] === 1'b1, "R8 reset flag set", int'(rdata[2]), 1);
        // R6: restart inside the grace window cancels
        tag = "R6"; r = rst_seen; wr(0, 8'h47);
        wait (m_armed); idle(5); wr(0, 8'h47); idle(30);
        chk(rst_seen == r, "R6 reset cancelled", rst_seen - r, 0);
        // R7: reset disabled, periodic alarm continues
        tag = "R7"; r = rst_seen; wr(0, 8'h44); idle(300);
        chk(rst_seen == r, "R7 no reset when disabled", rst_seen - r, 0);
        // R11: stop freezes count and grace
        tag = "R11"; wr(0, 8'h47); idle(30); stop_i = 1'b1; idle(100); stop_i = 1'b0;
        idle(20); wait (m_armed); idle(4); stop_i = 1'b1; idle(50); stop_i = 1'b0; idle(30);
        // R12: power-fail flag rules
        tag = "R12"; wr(0, 8'h44); pfail_i = 1'b1; idle(1); pfail_i = 1'b0; idle(2);
        chk(rdata[4] === 1'b1, "R12 flag from input", int'(rdata[4]), 1);
        wr(0, 8'h64); idle(2); wr(0, 8'h74); idle(2);
        chk(irq === 1'b1, "R12 forced interrupt", int'(irq), 1);
        // R13: priority with both pending
        tag = "R13"; wait (m_wdint); idle(2);
        chk(src === 1'b0, "R13 power-fail first", int'(src), 0);
        wr(0, 8'h6C); idle(2);
        chk(src === 1'b1, "R13 watchdog alone", int'(src), 1);
        // R9: power-on flag cleared only by write 0
        tag = "R9"; wr(0, 8'h04); idle(3);
        chk(rdata[6] === 1'b0, "R9 por flag cleared", int'(rdata[6]), 0);
        // R1, R8: power-on reset clears the watchdog reset flag
        tag = "R1"; por_n = 1'b0; idle(2); por_n = 1'b1; idle(2);
        chk(rdata === 8'h40, "R8 por clears reset flag", int'(rdata), 'h40);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule